// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address Filtering

This block takes an asynchronous serial line and turns it into a stream of received characters. The line is oversampled 16 times per bit by an enable pulse from a baud generator outside the block. A frame starts with a low start bit, carries 8 or 9 data bits least significant first, an optional parity bit in 8-bit mode, and one stop bit. Each finished character is stored, together with its own parity-error and framing-error flags, in a small receive queue. The consumer drains the queue through a valid/ready output stream.

In 9-bit mode an optional filter admits only characters whose ninth bit is set, so that a node on a multi-drop line only sees address characters until its software switches the filter off. The status pins report an idle receiver, data available, the error flags of the character at the head of the queue, and a sticky overrun flag. A clear pulse on the overrun flag empties the queue and aborts any character being shifted in.

Output stream rules: `out_valid` is high whenever the queue holds a character. A character is removed on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the head character and its flags stay unchanged. The only exception is an overrun clear, which empties the queue. The receiver cannot be stalled: back-pressure fills the queue and then leads to overrun.

Top module: `serial_rx_core`

## Requirements
- R1: A frame starts on a falling edge of `rx_in` seen while the receiver is idle. The start bit is confirmed low 8 ticks later, and a low pulse shorter than that is ignored. Each data bit is sampled 16 ticks after the previous sample, least significant bit first: 8 bits when `cfg_nine`=0, 9 bits when `cfg_nine`=1.
- R2: In 8-bit mode `cfg_parity` selects the parity check: 2'b01 even, 2'b10 odd, 2'b00 or 2'b11 none. A parity bit follows the data only when even or odd is selected. `out_perr` is 1 for a character whose parity bit does not match. In 9-bit mode no parity bit is received and the flag is 0.
- R3: A stop bit sampled as 0 sets the character's framing-error flag, and the character is still queued.
- R4: `out_perr` and `out_ferr` describe only the character at the head of the queue, and both are 0 while the queue is empty.
- R5: The queue holds FIFO_DEPTH (default 4) characters in arrival order. `out_valid` and `st_avail` are 1 exactly when it is non-empty, and the head holds steady while `out_valid` is high and `out_ready` is low.
- R6: When `cfg_nine`=1 and `cfg_addr_en`=1, only characters with data bit 8 = 1 are queued. When `cfg_nine`=0, `cfg_addr_en` has no effect.
- R7: `st_idle` is 1 when no character is being received and 0 from start-bit detection until the stop bit is sampled.
- R8: An admitted character that completes while the queue is full sets `st_overrun` and is lost. While `st_overrun` is set, further characters are discarded, the queued entries are kept, and the flag stays set.
- R9: A one-cycle `ovr_clr` pulse while `st_overrun`=1 clears the flag, empties the queue and abandons any character in progress, leaving `st_idle`=1. A pulse while `st_overrun`=0 has no effect.
- R10: In 8-bit mode `out_data[8]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit time |
| rx_in | input | 1 | Serial line, idle high |
| cfg_nine | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| cfg_parity | input | 2 | 01 even, 10 odd, other none (8-bit mode only) |
| cfg_addr_en | input | 1 | Admit only characters with bit 8 set (9-bit mode) |
| out_valid | output | 1 | Queue head holds a character |
| out_ready | input | 1 | Consumer takes the head character |
| out_data | output | 9 | Head character data |
| out_perr | output | 1 | Parity error of the head character |
| out_ferr | output | 1 | Framing error of the head character |
| st_idle | output | 1 | Receiver not inside a frame |
| st_avail | output | 1 | At least one character can be read |
| st_overrun | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clear pulse for the overrun flag |

## Verification
The hardest state to reach from the ports is an overrun clear that arrives while a frame is still being shifted in. The shift register is otherwise never visible, and its abort shows only as an early return of `st_idle` and as no character after the line goes quiet. The stimulus fills the queue without draining it, forces an overrun with one more frame, then starts an all-ones frame and pulses the clear during its data bits. The line then has no further falling edge, so any character left over from the aborted frame would appear at the output. Random frames with random mode, parity and injected errors are mixed with address-filter, glitch and back-pressure cases.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int DATA_W = 9;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_word_t;

  localparam int WORD_W = $bits(rx_word_t);

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF  = 2'b11
  } parity_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_e;

endpackage

// File: rtl/rxq_sampler.sv
module rxq_sampler
  import rxq_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_in,
  input  logic       flush,
  input  logic       nine,
  input  logic [1:0] parity,
  output logic       done,
  output rx_word_t   word,
  output logic       idle
);

  localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e         state;
  logic [1:0]        sync_q;
  logic              rx_prev;
  logic              fall_pend;
  logic [CW-1:0]     cnt;
  logic [3:0]        bit_idx;
  logic [DATA_W-1:0] sh;
  logic              par_q;

  logic rx_s;
  logic fall;
  logic use_par;
  logic [3:0] last_bit;
  logic par_bad;

  assign rx_s     = sync_q[1];
  assign fall     = rx_prev & ~rx_s;
  assign use_par  = ~nine & ((parity == PAR_EVEN) | (parity == PAR_ODD));
  assign last_bit = nine ? 4'd8 : 4'd7;
  assign par_bad  = use_par & ((^sh[7:0]) ^ par_q ^ (parity == PAR_ODD));
  assign idle     = (state == S_IDLE);

  // two-flop synchronizer and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      rx_prev <= 1'b1;
    end else begin
      sync_q  <= {sync_q[0], rx_in};
      rx_prev <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      fall_pend <= 1'b0;
      cnt       <= '0;
      bit_idx   <= '0;
      sh        <= '0;
      par_q     <= 1'b0;
      done      <= 1'b0;
      word      <= '0;
    end else begin
      done <= 1'b0;
      if (flush) begin
        state     <= S_IDLE;
        fall_pend <= 1'b0;
        cnt       <= '0;
        bit_idx   <= '0;
        sh        <= '0;
        par_q     <= 1'b0;
      end else begin
        if (state == S_IDLE && fall) fall_pend <= 1'b1;
        if (tick) begin
          unique case (state)
            S_IDLE: begin
              if (fall || fall_pend) begin
                state     <= S_START;
                cnt       <= '0;
                fall_pend <= 1'b0;
                sh        <= '0;
              end
            end
            S_START: begin
              if (cnt == MID) begin
                cnt     <= '0;
                bit_idx <= '0;
                state   <= rx_s ? S_IDLE : S_DATA;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_DATA: begin
              if (cnt == LAST) begin
                cnt         <= '0;
                sh[bit_idx] <= rx_s;
                if (bit_idx == last_bit) state <= use_par ? S_PAR : S_STOP;
                else bit_idx <= bit_idx + 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_PAR: begin
              if (cnt == LAST) begin
                cnt   <= '0;
                par_q <= rx_s;
                state <= S_STOP;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_STOP: begin
              if (cnt == LAST) begin
                cnt       <= '0;
                done      <= 1'b1;
                word.data <= sh;
                word.perr <= par_bad;
                word.ferr <= ~rx_s;
                state     <= S_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slot [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [CNTW-1:0]  level;
  logic             do_push;
  logic             do_pop;

  assign empty   = (level == '0);
  assign full    = (level == CNTW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = slot[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // one storage register per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot[g] <= '0;
      else if (do_push && !flush && wr_ptr == AW'(g)) slot[g] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end

endmodule

// File: rtl/rxq_admit.sv
module rxq_admit
  import rxq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     done,
  input  rx_word_t word,
  input  logic     nine,
  input  logic     addr_en,
  input  logic     full,
  input  logic     ovr_clr,
  output logic     push,
  output logic     flush,
  output logic     overrun
);

  logic accept;

  assign accept = ~(nine & addr_en) | word.data[8];
  assign flush  = overrun & ovr_clr;
  assign push   = done & accept & ~full & ~overrun & ~flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun <= 1'b0;
    else if (flush) overrun <= 1'b0;
    else if (done && accept && full) overrun <= 1'b1;
  end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import rxq_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_in,
  input  logic       cfg_nine,
  input  logic [1:0] cfg_parity,
  input  logic       cfg_addr_en,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [8:0] out_data,
  output logic       out_perr,
  output logic       out_ferr,
  output logic       st_idle,
  output logic       st_avail,
  output logic       st_overrun,
  input  logic       ovr_clr
);

  logic     smp_done;
  rx_word_t smp_word;
  logic     push;
  logic     flush;
  logic     q_empty;
  logic     q_full;
  rx_word_t head;

  rxq_sampler #(.OSR(OSR)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick16),
    .rx_in  (rx_in),
    .flush  (flush),
    .nine   (cfg_nine),
    .parity (cfg_parity),
    .done   (smp_done),
    .word   (smp_word),
    .idle   (st_idle)
  );

  rxq_admit u_adm (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (smp_done),
    .word    (smp_word),
    .nine    (cfg_nine),
    .addr_en (cfg_addr_en),
    .full    (q_full),
    .ovr_clr (ovr_clr),
    .push    (push),
    .flush   (flush),
    .overrun (st_overrun)
  );

  rxq_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .push_data (smp_word),
    .pop       (out_ready),
    .head      (head),
    .empty     (q_empty),
    .full      (q_full)
  );

  assign out_valid = ~q_empty;
  assign st_avail  = ~q_empty;
  assign out_data  = head.data;
  assign out_perr  = out_valid & head.perr;
  assign out_ferr  = out_valid & head.ferr;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [8:0] out_data,
  input logic       out_perr,
  input logic       out_ferr,
  input logic       st_idle,
  input logic       st_overrun,
  input logic       ovr_clr,
  input logic       cfg_nine,
  input logic       cfg_addr_en,
  input logic       push,
  input logic       push_bit8,
  input logic       q_full
);

  // R4: no flags reported for an empty queue
  a_r4_empty_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_perr && !out_ferr));

  // R5: head holds while the consumer stalls
  a_r5_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !(st_overrun && ovr_clr))
      |=> (out_valid && $stable(out_data) && $stable(out_perr) && $stable(out_ferr)));

  // R6: filter admits only address characters
  a_r6_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
    (push && cfg_nine && cfg_addr_en) |-> push_bit8);

  // R8: overrun stays until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_overrun && !ovr_clr) |=> st_overrun);

  // R8: overrun only rises with a full queue
  a_r8_set_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_overrun) |-> $past(q_full));

  // R8: nothing enters the queue while overrun is set
  a_r8_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    st_overrun |-> !push);

  // R9: clear empties the queue and aborts reception
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (st_overrun && ovr_clr) |=> (!out_valid && !st_overrun && st_idle));

endmodule

bind serial_rx_core rxq_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_perr    (out_perr),
  .out_ferr    (out_ferr),
  .st_idle     (st_idle),
  .st_overrun  (st_overrun),
  .ovr_clr     (ovr_clr),
  .cfg_nine    (cfg_nine),
  .cfg_addr_en (cfg_addr_en),
  .push        (push),
  .push_bit8   (smp_word.data[8]),
  .q_full      (q_full)
);

// File: tb/tb_serial_rx_core.sv
module tb_serial_rx_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b1;
  logic       rx_in = 1'b1;
  logic       cfg_nine = 1'b0;
  logic [1:0] cfg_parity = 2'b00;
  logic       cfg_addr_en = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [8:0] out_data;
  logic       out_perr;
  logic       out_ferr;
  logic       st_idle;
  logic       st_avail;
  logic       st_overrun;
  logic       ovr_clr = 1'b0;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;
  logic [10:0] expq[$];
  bit  m_ovr = 0;

  always #5 clk = ~clk;

  serial_rx_core dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
    .cfg_nine(cfg_nine), .cfg_parity(cfg_parity), .cfg_addr_en(cfg_addr_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_perr(out_perr), .out_ferr(out_ferr), .st_idle(st_idle),
    .st_avail(st_avail), .st_overrun(st_overrun), .ovr_clr(ovr_clr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit par_on();
    return !cfg_nine && (cfg_parity == 2'b01 || cfg_parity == 2'b10);
  endfunction

  function automatic logic [10:0] exp_word(input logic [8:0] d, input bit bad_par, input bit bad_stop);
    logic [8:0] v;
    v = cfg_nine ? d : {1'b0, d[7:0]};
    return {v, par_on() && bad_par, bad_stop};
  endfunction

  task automatic model_push(input logic [8:0] d, input bit bad_par, input bit bad_stop);
    if (cfg_nine && cfg_addr_en && !d[8]) return;
    if (m_ovr) return;
    if (expq.size() == 4) begin m_ovr = 1; return; end
    expq.push_back(exp_word(d, bad_par, bad_stop));
  endtask

  task automatic bit_out(input logic v);
    rx_in = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] d, input bit bad_par, input bit bad_stop);
    logic pb;
    bit_out(1'b0);
    for (int i = 0; i < (cfg_nine ? 9 : 8); i++) bit_out(d[i]);
    if (par_on()) begin
      pb = (^d[7:0]) ^ (cfg_parity == 2'b10) ^ bad_par;
      bit_out(pb);
    end
    bit_out(!bad_stop);
    rx_in = 1'b1;
    repeat (4) @(negedge clk);
    model_push(d, bad_par, bad_stop);
  endtask

  task automatic pop_one();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic drain();
    logic [10:0] e;
    while (expq.size() > 0) begin
      e = expq.pop_front();
      chk(out_valid == 1'b1, "R5 valid", out_valid, 1);
      chk(out_data == e[10:2], "R1 R10 data", out_data, e[10:2]);
      chk(out_perr == e[1], "R2 perr", out_perr, e[1]);
      chk(out_ferr == e[0], "R3 R4 ferr", out_ferr, e[0]);
      repeat ($urandom % 3) @(negedge clk);
      pop_one();
    end
    chk(st_avail == 1'b0, "R5 empty", st_avail, 0);
    chk(out_perr == 1'b0 && out_ferr == 1'b0, "R4 empty flags", {out_perr, out_ferr}, 0);
  endtask

  task automatic clr_pulse();
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(st_idle == 1'b1, "R7 reset idle", st_idle, 1);
    chk(st_avail == 1'b0, "R5 reset avail", st_avail, 0);
    chk(st_overrun == 1'b0, "R8 reset overrun", st_overrun, 0);
    chk(out_valid == 1'b0, "R5 reset valid", out_valid, 0);

    // short glitch is rejected
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b1;
    repeat (40) @(negedge clk);
    chk(st_idle == 1'b1, "R1 glitch idle", st_idle, 1);
    chk(st_avail == 1'b0, "R1 glitch no char", st_avail, 0);

    // idle goes low during a frame
    fork
      send_frame(9'h0A5, 0, 0);
      begin
        repeat (60) @(negedge clk);
        chk(st_idle == 1'b0, "R7 busy", st_idle, 0);
      end
    join
    chk(st_idle == 1'b1, "R7 idle after", st_idle, 1);
    drain();

    // address filter
    cfg_nine = 1'b1; cfg_addr_en = 1'b1;
    send_frame(9'h055, 0, 0);
    chk(st_avail == 1'b0, "R6 data char dropped", st_avail, 0);
    send_frame(9'h1AA, 0, 0);
    chk(st_avail == 1'b1, "R6 address char kept", st_avail, 1);
    drain();
    cfg_nine = 1'b0;
    send_frame(9'h005, 0, 0);
    chk(st_avail == 1'b1, "R6 ignored in 8-bit", st_avail, 1);
    drain();
    cfg_addr_en = 1'b0;

    // random traffic
    for (int n = 0; n < 50; n++) begin
      cfg_nine    = ($urandom % 3) == 0;
      cfg_parity  = 2'($urandom % 4);
      cfg_addr_en = ($urandom % 4) == 0;
      for (int k = 0; k < 1 + int'($urandom % 3); k++)
        send_frame(9'($urandom), ($urandom % 5) == 0, ($urandom % 6) == 0);
      drain();
    end
    cfg_nine = 1'b0; cfg_parity = 2'b01; cfg_addr_en = 1'b0;

    // overrun with flags per entry
    send_frame(9'h011, 1, 0);
    send_frame(9'h022, 0, 1);
    send_frame(9'h033, 0, 0);
    send_frame(9'h044, 0, 0);
    chk(st_overrun == 1'b0, "R8 full no overrun", st_overrun, 0);
    chk(out_perr == 1'b1 && out_ferr == 1'b0, "R4 head flags", {out_perr, out_ferr}, 2'b10);
    send_frame(9'h055, 0, 0);
    chk(st_overrun == 1'b1, "R8 overrun set", st_overrun, 1);
    send_frame(9'h066, 0, 1);
    chk(out_data == 9'h011, "R8 head kept", out_data, 9'h011);
    pop_one();
    void'(expq.pop_front());
    chk(out_data == 9'h022 && out_ferr == 1'b1 && out_perr == 1'b0, "R4 next head flags",
        {out_data, out_perr, out_ferr}, {9'h022, 2'b01});
    send_frame(9'h077, 0, 0);
    chk(st_overrun == 1'b1, "R8 still set", st_overrun, 1);
    drain();
    chk(st_overrun == 1'b1, "R8 sticky after drain", st_overrun, 1);
    clr_pulse();
    m_ovr = 0;
    chk(st_overrun == 1'b0, "R9 cleared", st_overrun, 0);

    // clear when not set has no effect
    send_frame(9'h03C, 0, 0);
    clr_pulse();
    chk(st_avail == 1'b1, "R9 no effect", st_avail, 1);
    drain();

    // clear flushes queue and aborts a frame
    cfg_parity = 2'b00;
    for (int k = 0; k < 5; k++) send_frame(9'(k + 1), 0, 0);
    chk(st_overrun == 1'b1, "R8 overrun again", st_overrun, 1);
    fork
      send_frame(9'h0FF, 0, 0);
      begin
        repeat (60) @(negedge clk);
        clr_pulse();
        @(negedge clk);
        chk(st_idle == 1'b1, "R9 aborted idle", st_idle, 1);
        chk(st_avail == 1'b0, "R9 queue empty", st_avail, 0);
      end
    join
    expq.delete();
    m_ovr = 0;
    chk(st_avail == 1'b0, "R9 no leftover char", st_avail, 0);
    chk(st_overrun == 1'b0, "R9 flag low", st_overrun, 0);
    send_frame(9'h0C3, 0, 0);
    drain();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule